// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Driver

This block holds the output latch for a port of quasi-bidirectional pins and turns it into per-pin drive enables. No direction register exists: a pin whose latch bit is 0 pulls low, and a pin whose latch bit is 1 carries only a weak pull-up. In that state an external driver can pull the pin low, so the same pin serves as an input. A pin that a write moves from 0 to 1 also gets a strong pull-up for a short time, so that a heavily loaded line rises quickly. The first falling edge of the serial bus clock after that write turns the strong pull-up off again.

A bus front end presents each complete port value on a one-cycle strobe. The serial clock line enters asynchronously and passes through a synchronizer before its falling edges are detected. The pad levels are resynchronized and returned as the sampled port value, which reads and change detection use.

Top module: `qbd_port_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, every latch bit is 1. Then `pu_weak_en` is all ones, `pu_strong_en` and `pd_en` are all zeros, and `port_val` is all ones.
- R2: A write (`wr_stb`=1 at an edge) loads `wr_data` into the latch at that edge. From then on each bit i gives `pu_weak_en[i]`=`wr_data[i]` and `pd_en[i]`=NOT `wr_data[i]`.
- R3: Each bit that a write moves from 0 to 1 has `pu_strong_en` set from that edge on.
- R4: A write that keeps a bit at 1 does not set that bit's strong pull-up when it was off. A write of 0 to a bit clears that bit's strong pull-up.
- R5: `scl_in` passes through a two-flop synchronizer. A 1-to-0 change at its output clears all strong pull-ups at the following edge, so a low level first sampled at edge k clears them at edge k+2. A rising SCL has no effect.
- R6: On any pin, `pd_en` is never high together with `pu_weak_en` or `pu_strong_en`.
- R7: `pu_strong_en[i]` is high only while `pu_weak_en[i]` is high.
- R8: `port_val` equals `pad_in` as it was two clock edges earlier.
- R9: When a write and a detected SCL fall take effect at the same edge, the bits newly armed by that write stay armed, and all other strong pull-ups are cleared.
- R10: Without a write, the latch and so `pu_weak_en` and `pd_en` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle strobe that loads a new latch value |
| wr_data | input | NPINS | New latch value, bit i for pin i |
| scl_in | input | 1 | Asynchronous serial bus clock line |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pu_weak_en | output | NPINS | Weak pull-up enable per pin |
| pu_strong_en | output | NPINS | Momentary strong pull-up enable per pin |
| pd_en | output | NPINS | Pull-down enable per pin |
| port_val | output | NPINS | Synchronized pad levels |

## Verification
The assertions check on every cycle that a pull-down never overlaps a pull-up and that a strong pull-up always sits on a latched-high pin. They also check that the latch holds between writes, that every 0-to-1 write arms its pins, and that the sampled value lags the pads by two cycles. Only the bench's scenarios show three further behaviours. The first is the exact cycle at which a synchronized SCL fall cuts the strong pull-ups. The second is that a 1-to-1 rewrite leaves a disarmed pin disarmed. The third is that a write which coincides with a fall keeps only its newly armed bits.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
  // Bits that a write moves from low to high
  function automatic logic [63:0] rise_bits(input logic [63:0] old_v, input logic [63:0] new_v);
    return ~old_v & new_v;
  endfunction
endpackage

// File: rtl/qbd_sync.sv
module qbd_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/qbd_latch.sv
module qbd_latch #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [NPINS-1:0] wr_data,
  input  logic             scl_fall,
  output logic [NPINS-1:0] lat_q,
  output logic [NPINS-1:0] strong_q
);
  import qbd_pkg::*;
  logic [63:0] rise_w;
  logic [NPINS-1:0] arm, kept;

  assign rise_w = rise_bits(64'(lat_q), 64'(wr_data));
  assign arm    = rise_w[NPINS-1:0];
  // A fall drops every armed bit, then a write keeps only pins it leaves high
  assign kept   = scl_fall ? '0 : strong_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q    <= '1;
      strong_q <= '0;
    end else if (wr_stb) begin
      lat_q    <= wr_data;
      strong_q <= (kept & wr_data) | arm;
    end else begin
      strong_q <= kept;
    end
  end
endmodule

// File: rtl/qbd_port_ctrl.sv
module qbd_port_ctrl #(
  parameter int NPINS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [NPINS-1:0] wr_data,
  input  logic             scl_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pu_weak_en,
  output logic [NPINS-1:0] pu_strong_en,
  output logic [NPINS-1:0] pd_en,
  output logic [NPINS-1:0] port_val
);
  logic scl_s, scl_prev, scl_fall;
  logic [NPINS-1:0] lat_q, strong_q;

  qbd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
    .clk(clk), .rst(rst), .d(scl_in), .q(scl_s)
  );

  always_ff @(posedge clk) begin
    if (rst) scl_prev <= 1'b1;
    else     scl_prev <= scl_s;
  end
  assign scl_fall = scl_prev & ~scl_s;

  qbd_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES), .RST_VAL({NPINS{1'b1}})) u_pad_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(port_val)
  );

  qbd_latch #(.NPINS(NPINS)) u_latch (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
    .scl_fall(scl_fall), .lat_q(lat_q), .strong_q(strong_q)
  );

  assign pu_weak_en   = lat_q;
  assign pd_en        = ~lat_q;
  assign pu_strong_en = strong_q;
endmodule

// File: rtl/qbd_port_ctrl_chk.sv
module qbd_port_ctrl_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_stb,
  input logic [NPINS-1:0] wr_data,
  input logic [NPINS-1:0] pad_in,
  input logic [NPINS-1:0] pu_weak_en,
  input logic [NPINS-1:0] pu_strong_en,
  input logic [NPINS-1:0] pd_en,
  input logic [NPINS-1:0] port_val
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    (pd_en & (pu_weak_en | pu_strong_en)) == '0);

  assert_strong_on_high_R7: assert property (@(posedge clk) disable iff (rst)
    (pu_strong_en & ~pu_weak_en) == '0);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!wr_stb && age != 2'd0) |=> ($stable(pu_weak_en) && $stable(pd_en)));

  assert_arm_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && age != 2'd0) |=> ((~$past(pu_weak_en) & $past(wr_data) & ~pu_strong_en) == '0));

  assert_sample_lag_R8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (port_val == $past(pad_in, 2)));
endmodule

bind qbd_port_ctrl qbd_port_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .pad_in(pad_in),
  .pu_weak_en(pu_weak_en), .pu_strong_en(pu_strong_en), .pd_en(pd_en),
  .port_val(port_val)
);

// File: tb/sim_qbd_port_ctrl.sv
`timescale 1ns/1ps
module sim_qbd_port_ctrl;
  localparam int N = 16;
  logic clk = 0, rst = 1, wr_stb = 0, scl_in = 1;
  logic [N-1:0] wr_data = '0, pad_in = '1;
  logic [N-1:0] pu_weak_en, pu_strong_en, pd_en, port_val;
  int errors = 0, checks = 0;

  // bench model
  logic [N-1:0] m_lat, m_str, m_p1, m_pv;
  logic m_s1, m_s2, m_prev;

  qbd_port_ctrl #(.NPINS(N)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_lat = '1; m_str = '0; m_p1 = '1; m_pv = '1;
    m_s1 = 1; m_s2 = 1; m_prev = 1;
  endtask

  // Drive at negedge, clock once, update model, check at next negedge
  task automatic step(logic w, logic [N-1:0] d, logic s, logic [N-1:0] p);
    logic fall;
    logic [N-1:0] kept;
    wr_stb = w; wr_data = d; scl_in = s; pad_in = p;
    @(posedge clk);
    fall = m_prev & ~m_s2;
    kept = fall ? '0 : m_str;
    if (w) begin
      m_str = (kept & d) | (~m_lat & d);
      m_lat = d;
    end else m_str = kept;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = s;
    m_pv = m_p1; m_p1 = p;
    @(negedge clk);
    chk("R2 R10 weak", pu_weak_en, m_lat);
    chk("R2 R10 pd", pd_en, ~m_lat);
    chk("R3 R4 R5 R9 strong", pu_strong_en, m_str);
    chk("R8 port_val", port_val, m_pv);
    chk("R6 R7 overlap", (pd_en & (pu_weak_en | pu_strong_en)) | (pu_strong_en & ~pu_weak_en), '0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
    chk("R1 weak", pu_weak_en, '1);
    chk("R1 strong", pu_strong_en, '0);
    chk("R1 pd", pd_en, '0);
    chk("R1 port_val", port_val, '1);

    // directed: R2 clear all, R3 arm low byte
    step(1, 16'h0000, 1, 16'hA5A5);
    step(1, 16'h00FF, 1, 16'h5A5A);
    chk("R3 directed arm", pu_strong_en, 16'h00FF);
    // R5 fall timing: strong stays two edges, cleared on the third
    step(0, 0, 0, 16'h1234);
    step(0, 0, 0, 16'h1234);
    chk("R5 before clear", pu_strong_en, 16'h00FF);
    step(0, 0, 0, 16'h1234);
    chk("R5 cleared", pu_strong_en, 16'h0000);
    // R5 rising SCL no effect; R4 1->1 not re-armed, only 0->1 bits arm
    step(0, 0, 1, 16'h1234);
    step(0, 0, 1, 16'h1234);
    step(1, 16'h0FFF, 1, 16'h1234);
    chk("R4 rewrite high", pu_strong_en, 16'h0F00);
    step(1, 16'hF0FF, 1, 16'h1234);
    chk("R4 zero clears", pu_strong_en, 16'hF000);
    // R9 write coinciding with detected fall
    step(1, 16'h0000, 1, 16'h0);
    step(1, 16'h000F, 1, 16'h0);
    step(0, 0, 0, 16'h0);
    step(0, 0, 0, 16'h0);
    step(1, 16'h00FF, 0, 16'h0);
    chk("R9 same edge", pu_strong_en, 16'h00F0);

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 3) == 0, N'($urandom), ($urandom % 4) != 0, N'($urandom));
    end

    // R1 reset mid-run
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    model_reset();
    chk("R1 reapplied weak", pu_weak_en, '1);
    chk("R1 reapplied strong", pu_strong_en, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule